// File: doc/BRIEF.md
# Address Window Decoder

The decoder sits between a bus master and the interconnect and turns each request address into a routing decision. It holds a small set of address windows. Each window is described by a control word (enable, target identifier, attribute byte, size) and a base word, and both are written through a flat register port. For every valid request the block finds the lowest-numbered enabled window that covers the address. One clock later it reports whether a window was hit, together with that window's target identifier and attribute byte.

Sizes and bases work at 64 KiB granularity. The control word carries the size as the upper half of (size − 1), which gives a mask. A window covers an address when the masked upper half of the address equals the stored base. Each window also keeps a remap word that software can read back. The remap word takes no part in matching.

The response stage is a small state machine with three named states. `ST_IDLE` means no response is pending. `ST_HIT` means the request found a window. `ST_MISS` means it found none. On every clock edge the next state is chosen as follows:
- `ST_HIT` when a request is present and at least one window matches.
- `ST_MISS` when a request is present and no window matches.
- `ST_IDLE` when no request is present.

The state can move from any state to any other. The outputs are decoded from the state alone.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset every window is disabled, every control, base and remap register reads zero, and no response is pending.
- R2: In a control word, bit 0 enables the window, bits 7:4 hold the target identifier, bits 15:8 hold the attribute byte and bits 31:16 hold the upper half of (size − 1). Bits 3:1 are not stored and read as zero.
- R3: The base register stores only bits 31:16 and reads zero in bits 15:0. The low 16 request address bits never affect matching.
- R4: Window w occupies byte offsets 16·w + 0 (control), 16·w + 4 (base) and 16·w + 12 (remap). Offset 16·w + 8, and any window index of NUM_WIN or above, reads zero and ignores writes.
- R5: A window matches when it is enabled and (addr[31:16] & ~size_m1) equals its stored base.
- R6: A disabled window never matches, whatever its size and base.
- R7: When several windows match, the lowest-numbered one supplies the target and attribute.
- R8: On a miss, and whenever no response is valid, the hit, target and attribute outputs are zero.
- R9: A request sampled at a clock edge produces rsp_valid and its result right after that same edge, one cycle after it is presented. A register write presented in the same cycle as a request does not affect that request.
- R10: The remap register stores bits 31:16 (reads zero below) and has no effect on matching.
- R11: A window whose base has bits set inside its size mask never matches any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid (one cycle after request) |
| rsp_hit | output | 1 | A window matched |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |

## Verification
The assertions assume that cfg_addr is word aligned and that req_valid is a plain level, not a handshake. A response therefore exists exactly when a request was present at the previous edge. They also assume that configuration changes reach the decode only at a clock edge. The stimulus drives every input at the falling edge, uses only aligned offsets and keeps each request valid for one cycle, so these conditions hold. It also presents a write and a request in the same cycle to exercise the old-configuration rule.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic        en;
    } win_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_t;

    localparam logic [1:0] SLOT_CTRL  = 2'd0;
    localparam logic [1:0] SLOT_BASE  = 2'd1;
    localparam logic [1:0] SLOT_REMAP = 2'd3;

    function automatic logic [31:0] ctrl_to_word(win_ctrl_t c);
        return {c.size_m1, c.attr, c.target, 3'b000, c.en};
    endfunction

endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output win_ctrl_t         ctrl_q [NUM_WIN],
    output logic [15:0]       base_q [NUM_WIN]
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [1:0]       slot;
    win_ctrl_t        ctrl_r  [NUM_WIN];
    logic [15:0]      base_r  [NUM_WIN];
    logic [15:0]      remap_r [NUM_WIN];
    logic             unused_cfg;

    assign idx        = cfg_addr[ADDR_W-1:4];
    assign slot       = cfg_addr[3:2];
    assign unused_cfg = ^{cfg_addr[1:0], cfg_wdata[3:1]};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_r[w]  <= '0;
                base_r[w]  <= '0;
                remap_r[w] <= '0;
            end else if (cfg_we && idx == IDX_W'(w)) begin
                case (slot)
                    SLOT_CTRL: begin
                        ctrl_r[w].size_m1 <= cfg_wdata[31:16];
                        ctrl_r[w].attr    <= cfg_wdata[15:8];
                        ctrl_r[w].target  <= cfg_wdata[7:4];
                        ctrl_r[w].en      <= cfg_wdata[0];
                    end
                    SLOT_BASE:  base_r[w]  <= cfg_wdata[31:16];
                    SLOT_REMAP: remap_r[w] <= cfg_wdata[31:16];
                    default: ;
                endcase
            end
        end

        assign ctrl_q[w] = ctrl_r[w];
        assign base_q[w] = base_r[w];

        // R2: a control write sets the enable from data bit 0
        assert_ctrl_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && idx == IDX_W'(w) && slot == SLOT_CTRL)
            |=> (ctrl_r[w].en == $past(cfg_wdata[0])));
    end

    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (idx == IDX_W'(w)) begin
                case (slot)
                    SLOT_CTRL:  cfg_rdata = ctrl_to_word(ctrl_r[w]);
                    SLOT_BASE:  cfg_rdata = {base_r[w], 16'h0000};
                    SLOT_REMAP: cfg_rdata = {remap_r[w], 16'h0000};
                    default:    cfg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 6
) (
    input  logic [15:0]        addr_hi,
    input  win_ctrl_t          ctrl [NUM_WIN],
    input  logic [15:0]        base [NUM_WIN],
    output logic [NUM_WIN-1:0] match
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign match[w] = ctrl[w].en &&
                          ((addr_hi & ~ctrl[w].size_m1) == base[w]);
    end
endmodule

// File: rtl/addrwin_prio.sv
module addrwin_prio #(
    parameter int NUM_WIN = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] match,
    output logic [NUM_WIN-1:0] grant,
    output logic               any
);
    always_comb begin
        grant = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                grant    = '0;
                grant[w] = 1'b1;
            end
        end
    end

    assign any = |match;

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_in_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~match) == '0);

    assert_grant_when_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant != '0));
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [3:0]        rsp_target,
    output logic [7:0]        rsp_attr
);
    win_ctrl_t          ctrl [NUM_WIN];
    logic [15:0]        base [NUM_WIN];
    logic [NUM_WIN-1:0] match, grant, en_vec;
    logic               any;
    logic [3:0]         sel_tgt, tgt_q;
    logic [7:0]         sel_attr, attr_q;
    rsp_state_t         state_q, state_d;
    logic               unused_low;

    assign unused_low = ^req_addr[15:0];

    addrwin_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_q(ctrl), .base_q(base)
    );

    addrwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr_hi(req_addr[31:16]), .ctrl(ctrl), .base(base), .match(match)
    );

    addrwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .clk(clk), .rst_n(rst_n), .match(match), .grant(grant), .any(any)
    );

    always_comb begin
        sel_tgt  = '0;
        sel_attr = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            en_vec[w] = ctrl[w].en;
            if (grant[w]) begin
                sel_tgt  = sel_tgt  | ctrl[w].target;
                sel_attr = sel_attr | ctrl[w].attr;
            end
        end
    end

    always_comb begin
        if (!req_valid)  state_d = ST_IDLE;
        else if (any)    state_d = ST_HIT;
        else             state_d = ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= (req_valid && any) ? sel_tgt  : '0;
            attr_q  <= (req_valid && any) ? sel_attr : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
            ST_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            ST_MISS: begin rsp_valid = 1'b1; rsp_hit = 1'b0; end
            default: begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
        endcase
        rsp_target = tgt_q;
        rsp_attr   = attr_q;
    end

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_target == '0 && rsp_attr == '0));

    assert_miss_is_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_target == '0 && rsp_attr == '0));

    assert_hit_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_disabled_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match & ~en_vec) == '0);

endmodule

// File: tb/test_addrwin_decoder.sv
module test_addrwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addrwin_decoder #(.NUM_WIN(6), .ADDR_W(8)) i_addrwin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_target(rsp_target), .rsp_attr(rsp_attr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 chk(tag, cfg_rdata, exp);
    endtask

    task automatic lookup(input string tag, input logic [31:0] a,
                          input logic h, input logic [3:0] t, input logic [7:0] at);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " hit"},   {31'd0, rsp_hit},   {31'd0, h});
        chk({tag, " target"}, {28'd0, rsp_target}, {28'd0, t});
        chk({tag, " attr"},  {24'd0, rsp_attr},  {24'd0, at});
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic t_reset;
        for (int w = 0; w < 6; w++) begin
            rd_chk("R1 ctrl after reset",  8'(16 * w),      32'h0);
            rd_chk("R1 base after reset",  8'(16 * w + 4),  32'h0);
            rd_chk("R1 remap after reset", 8'(16 * w + 12), 32'h0);
        end
        chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        lookup("R1 R8 reset miss", 32'h0000_0000, 1'b0, 4'h0, 8'h00);
    endtask

    task automatic t_fields;
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl field packing", 8'h00, 32'hFFFF_FFF1);
        wr(8'h04, 32'h1234_5678);
        rd_chk("R3 base low bits dropped", 8'h04, 32'h1234_0000);
        wr(8'h0C, 32'hABCD_1234);
        rd_chk("R10 remap stored", 8'h0C, 32'hABCD_0000);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R4 gap offset reads zero", 8'h08, 32'h0);
        wr(8'h60, 32'hFFFF_FFFF);
        rd_chk("R4 window six ignored", 8'h60, 32'h0);
        wr(8'h74, 32'hFFFF_FFFF);
        rd_chk("R4 window seven ignored", 8'h74, 32'h0);
        rd_chk("R4 window zero untouched", 8'h00, 32'hFFFF_FFF1);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h0C, 32'h0);
        rd_chk("R1 cleared ctrl", 8'h00, 32'h0);
    endtask

    task automatic t_priority;
        wr(8'h10, 32'h000F_5A31); wr(8'h14, 32'h0010_0000);
        wr(8'h30, 32'h00FF_C371); wr(8'h34, 32'h0000_0000);
        lookup("R7 lowest window wins", 32'h0010_0000, 1'b1, 4'h3, 8'h5A);
        lookup("R5 top of window", 32'h001F_FFFF, 1'b1, 4'h3, 8'h5A);
        lookup("R5 next window only", 32'h0020_0000, 1'b1, 4'h7, 8'hC3);
        lookup("R8 miss zeros", 32'h0100_0000, 1'b0, 4'h0, 8'h00);
        wr(8'h10, 32'h000F_5A30);
        lookup("R6 disabled window skipped", 32'h0010_0000, 1'b1, 4'h7, 8'hC3);
        wr(8'h30, 32'h0);
        lookup("R6 all disabled miss", 32'h0010_0000, 1'b0, 4'h0, 8'h00);
    endtask

    task automatic t_align;
        wr(8'h50, 32'h0000_2251); wr(8'h54, 32'h8000_0000);
        lookup("R3 low address ignored", 32'h8000_1234, 1'b1, 4'h5, 8'h22);
        lookup("R5 64KiB edge miss", 32'h8001_0000, 1'b0, 4'h0, 8'h00);
        wr(8'h5C, 32'h4000_0000);
        lookup("R10 remap no effect", 32'h8000_FFFF, 1'b1, 4'h5, 8'h22);
        lookup("R10 remap target not matched", 32'h4000_0000, 1'b0, 4'h0, 8'h00);
        wr(8'h40, 32'h000F_1141); wr(8'h44, 32'h4003_0000);
        lookup("R11 misaligned base a", 32'h4003_0000, 1'b0, 4'h0, 8'h00);
        lookup("R11 misaligned base b", 32'h4000_0000, 1'b0, 4'h0, 8'h00);
    endtask

    task automatic t_latency;
        wr(8'h04, 32'h9000_0000);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000;
        cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h0000_9961;
        #1 chk("R9 no result before edge", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk("R9 valid one cycle later", {31'd0, rsp_valid}, 32'd1);
        chk("R9 same-cycle write unseen", {31'd0, rsp_hit}, 32'd0);
        @(negedge clk);
        chk("R9 valid drops", {31'd0, rsp_valid}, 32'd0);
        chk("R8 idle target zero", {28'd0, rsp_target}, 32'd0);
        lookup("R9 new config used", 32'h9000_0000, 1'b1, 4'h6, 8'h99);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9 watchdog expired actual=running expected=done");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_priority();
        t_align();
        t_latency();
        done = 1'b1;
        finish_up();
    end
endmodule